// File: doc/BRIEF.md
# Twisted-Pair Receive Squelch Qualifier

This block decides when genuine data is arriving on a 10 Mb/s twisted-pair receive pair. It watches two digital comparator outputs: one goes high while the line is above the positive threshold, and the other goes high while the line is below the negative threshold. Noise bursts must not open the receive path. For that reason the block asserts its data-valid output only after a short alternating pattern: a crossing of one polarity, then a crossing of the opposite polarity, then the first polarity again. Each step must follow the previous one within a window of about 150 ns.

Once a packet is accepted, the block drives a select line that tells the analog front end to switch to lowered thresholds, so that weaker pulses in the packet body still count as line activity. The packet is considered over when neither comparator has been high for longer than the same window. At that point data-valid and the select line drop together, and the next packet must qualify again from the start. Duplex mode plays no part in this decision.

The window length is a parameter expressed in sampling-clock cycles. The comparator outputs are asynchronous to the clock, so they pass through a parameterised synchronizer before any decision is made.

Top module: `tp_squelch_qual`

## Requirements
- R1: In idle, a rising edge (low-to-high in the synchronized signal) on exactly one comparator starts a qualification attempt, and that polarity becomes the expected first polarity. Comparators that stay low leave data_valid low indefinitely.
- R2: The rising edge of the opposite comparator must be seen no more than CYCLES_150NS+1 cycles after the cycle of the first edge. If it has not arrived by then, the attempt is abandoned and the block returns to idle.
- R3: The original comparator must then rise again no more than CYCLES_150NS+1 cycles after the opposite edge, and only this third step sets data_valid. Further edges of the same polarity as the first one never advance the sequence.
- R4: thr_reduce_sel is high in exactly the cycles where data_valid is high.
- R5: While data_valid is high, any cycle with either synchronized comparator high counts as activity and restarts the quiet count, so data_valid stays high.
- R6: After CYCLES_150NS+1 consecutive cycles with neither synchronized comparator high, data_valid and thr_reduce_sel drop together and the block returns to idle. A comparator that is held high continuously afterwards does not requalify.
- R7: Each comparator passes through SYNC_STAGES flip-flops. Take the clock edge that first samples an input change as edge 0. The outputs react to that change at edge SYNC_STAGES.
- R8: While rst_n is low at a rising clock edge, both outputs are low after that edge and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_above_pos | input | 1 | Asynchronous comparator: line above positive threshold |
| cmp_below_neg | input | 1 | Asynchronous comparator: line below negative threshold |
| data_valid | output | 1 | High while a qualified packet is being received |
| thr_reduce_sel | output | 1 | Selects the lowered comparator thresholds |

## Verification
Every result is due a fixed number of edges after its stimulus. An input first sampled at edge k affects the outputs at edge k+SYNC_STAGES, which is two edges with the default setting. The bench applies one input value per cycle and samples just after each edge, so a qualification step, a window expiry or an end-of-packet decision made on sample k is checked exactly two samples later. The window edges are exercised at both sides: four quiet cycles between steps must pass and five must fail, and four quiet cycles inside a packet must keep it alive while five end it. The check one sample before the due cycle confirms that the result does not come early.

// File: rtl/sq_pkg.sv
// Shared types for the twisted-pair squelch qualifier.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sq_pkg;

    // Qualification progress
    typedef enum logic [1:0] {
        SQ_IDLE      = 2'd0,
        SQ_WAIT_OPP  = 2'd1,
        SQ_WAIT_ORIG = 2'd2,
        SQ_VALID     = 2'd3
    } sq_state_t;

    // Polarity of the crossing that opened the attempt
    typedef enum logic {
        SQ_POL_POS = 1'b0,
        SQ_POL_NEG = 1'b1
    } sq_pol_t;

endpackage

// File: rtl/sq_sync.sv
// Multi-stage synchronizer for the asynchronous comparator outputs.
// Assumes: each bit is an independent level; STAGES >= 1.
module sq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first flop captures the raw comparator level
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // later flops settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sq_edge.sv
// Turns synchronized comparator levels into rising-edge strobes and an
// activity flag. Assumes inputs are already synchronous to clk.
module sq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_pos,
    input  logic lvl_neg,
    output logic rise_pos,
    output logic rise_neg,
    output logic activity
);

    logic prev_pos;
    logic prev_neg;

    // remember last cycle's levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pos <= 1'b0;
            prev_neg <= 1'b0;
        end else begin
            prev_pos <= lvl_pos;
            prev_neg <= lvl_neg;
        end
    end

    assign rise_pos = lvl_pos & ~prev_pos;
    assign rise_neg = lvl_neg & ~prev_neg;
    assign activity = lvl_pos | lvl_neg;

endmodule

// File: rtl/sq_win_timer.sv
// Saturating window counter. Counts cycles since the last clear and flags
// when LIMIT cycles have passed. Assumes LIMIT >= 1.
module sq_win_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LIM);

    // count up to LIMIT, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (!expired)   cnt <= cnt + 1'b1;
    end

    // R2/R6: the window count never runs past its limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);

endmodule

// File: rtl/sq_seq_fsm.sv
// Qualification sequencer: first crossing, opposite crossing, original
// crossing, then valid until a quiet window. Assumes one shared window
// timer cleared by this module on every state change.
module sq_seq_fsm
    import sq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_pos,
    input  logic      rise_neg,
    input  logic      activity,
    input  logic      expired,
    output sq_state_t state,
    output logic      timer_clear
);

    sq_state_t state_nx;
    sq_pol_t   pol;
    sq_pol_t   pol_nx;
    logic      opp_rise;
    logic      orig_rise;

    // pick the edge expected at each step from the opening polarity
    always_comb begin
        opp_rise  = (pol == SQ_POL_POS) ? rise_neg : rise_pos;
        orig_rise = (pol == SQ_POL_POS) ? rise_pos : rise_neg;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        pol_nx   = pol;
        unique case (state)
            SQ_IDLE: begin
                if (rise_pos ^ rise_neg) begin
                    state_nx = SQ_WAIT_OPP;
                    pol_nx   = rise_neg ? SQ_POL_NEG : SQ_POL_POS;
                end
            end
            SQ_WAIT_OPP: begin
                if (opp_rise)     state_nx = SQ_WAIT_ORIG;
                else if (expired) state_nx = SQ_IDLE;
            end
            SQ_WAIT_ORIG: begin
                if (orig_rise)    state_nx = SQ_VALID;
                else if (expired) state_nx = SQ_IDLE;
            end
            SQ_VALID: begin
                if (!activity && expired) state_nx = SQ_IDLE;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    // restart the window on entry to any state and on packet activity
    assign timer_clear = (state_nx != state) || (state == SQ_IDLE) ||
                         ((state == SQ_VALID) && activity);

    // state and polarity registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            pol   <= SQ_POL_POS;
        end else begin
            state <= state_nx;
            pol   <= pol_nx;
        end
    end

    // R1: without a single-polarity rising edge idle is kept
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && !(rise_pos ^ rise_neg)) |=> state == SQ_IDLE);

    // R2: an expired first window with no opposite edge abandons the attempt
    a_r2_opp_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT_OPP && expired && !rise_pos && !rise_neg)
        |=> state == SQ_IDLE);

    // R3: valid is only ever entered from the third step
    a_r3_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == SQ_VALID) |-> $past(state) == SQ_WAIT_ORIG);

    // R5: activity during a packet keeps it open
    a_r5_activity_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_VALID && activity) |=> state == SQ_VALID);

    // R6: a full quiet window ends the packet
    a_r6_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_VALID && !activity && expired) |=> state == SQ_IDLE);

endmodule

// File: rtl/tp_squelch_qual.sv
// Twisted-pair receive squelch qualifier (top). Synchronizes the two
// comparator outputs, detects edges, runs the three-step qualification and
// drives data_valid plus the lowered-threshold select.
// Assumes: comparator outputs are asynchronous levels; CYCLES_150NS is the
// 150 ns window rounded to sampling-clock cycles.
module tp_squelch_qual
    import sq_pkg::*;
#(
    parameter int CYCLES_150NS = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_above_pos,
    input  logic cmp_below_neg,
    output logic data_valid,
    output logic thr_reduce_sel
);

    logic [1:0] lvl_s;
    logic       rise_pos;
    logic       rise_neg;
    logic       activity;
    logic       expired;
    logic       timer_clear;
    sq_state_t  state;

    sq_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_above_pos, cmp_below_neg}),
        .q     (lvl_s)
    );

    sq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_pos  (lvl_s[1]),
        .lvl_neg  (lvl_s[0]),
        .rise_pos (rise_pos),
        .rise_neg (rise_neg),
        .activity (activity)
    );

    sq_win_timer #(
        .LIMIT (CYCLES_150NS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .expired (expired)
    );

    sq_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_pos    (rise_pos),
        .rise_neg    (rise_neg),
        .activity    (activity),
        .expired     (expired),
        .state       (state),
        .timer_clear (timer_clear)
    );

    // outputs decode straight from the registered state, glitch free
    assign data_valid     = (state == SQ_VALID);
    assign thr_reduce_sel = (state == SQ_VALID);

    // R4: lowered thresholds exactly while valid
    a_r4_thr_matches: assert property (@(posedge clk) disable iff (!rst_n)
        thr_reduce_sel == data_valid);

    // R8: a reset edge leaves both outputs low
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!data_valid && !thr_reduce_sel));

endmodule

// File: tb/tp_squelch_qual_tb.sv
`timescale 1ns/1ps
// Directed bench for the squelch qualifier: one task per scenario.
module tp_squelch_qual_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_p = 1'b0;
    logic cmp_n = 1'b0;
    logic dv;
    logic thr;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    tp_squelch_qual #(
        .CYCLES_150NS (4),
        .SYNC_STAGES  (2)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmp_above_pos  (cmp_p),
        .cmp_below_neg  (cmp_n),
        .data_valid     (dv),
        .thr_reduce_sel (thr)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one sample: set inputs, let one edge capture them, settle just after
    task automatic drive(input logic p, input logic n);
        cmp_p = p;
        cmp_n = n;
        @(posedge clk);
        #1;
    endtask

    task automatic hold(input logic p, input logic n, input int cnt);
        for (int i = 0; i < cnt; i++) drive(p, n);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hold(0, 0, 3);
        rst_n = 1'b1;
        hold(0, 0, 3);
    endtask

    // positive-first qualification; outputs are due two samples after step 3
    task automatic qualify_pos();
        drive(1, 0);
        drive(0, 1);
        drive(1, 0);
        hold(1, 0, 2);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 reset data_valid", dv, 1'b0);
        chk("R8 reset thr_reduce_sel", thr, 1'b0);
    endtask

    task automatic t_quiet_and_lone();
        do_reset();
        hold(0, 0, 20);
        chk("R1 quiet line", dv, 1'b0);
        drive(1, 0);
        hold(0, 0, 12);
        chk("R2 lone pulse times out", dv, 1'b0);
        chk("R4 select idle", thr, 1'b0);
    endtask

    task automatic t_pnp();
        do_reset();
        drive(1, 0);
        drive(0, 1);
        drive(1, 0);
        chk("R7 not yet at step 3", dv, 1'b0);
        drive(1, 0);
        chk("R7 not early by one", dv, 1'b0);
        drive(0, 1);
        chk("R3 valid after P-N-P", dv, 1'b1);
        chk("R4 select with valid", thr, 1'b1);
    endtask

    task automatic t_npn();
        do_reset();
        drive(0, 1);
        drive(1, 0);
        drive(0, 1);
        hold(0, 1, 2);
        chk("R1 valid after N-P-N", dv, 1'b1);
    endtask

    task automatic t_same_pol();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            drive(1, 0);
            drive(0, 0);
        end
        hold(0, 0, 6);
        chk("R3 repeated same polarity never qualifies", dv, 1'b0);
    endtask

    task automatic t_win_opp();
        do_reset();
        drive(1, 0);
        hold(0, 0, 4);
        drive(0, 1);
        drive(1, 0);
        hold(1, 0, 2);
        chk("R2 opposite at window limit", dv, 1'b1);
        do_reset();
        drive(1, 0);
        hold(0, 0, 5);
        drive(0, 1);
        drive(1, 0);
        hold(0, 0, 12);
        chk("R2 opposite one cycle late", dv, 1'b0);
    endtask

    task automatic t_win_orig();
        do_reset();
        drive(1, 0);
        drive(0, 1);
        hold(0, 0, 4);
        drive(1, 0);
        hold(1, 0, 2);
        chk("R3 original at window limit", dv, 1'b1);
        do_reset();
        drive(1, 0);
        drive(0, 1);
        hold(0, 0, 5);
        drive(1, 0);
        hold(0, 0, 12);
        chk("R3 original one cycle late", dv, 1'b0);
    endtask

    task automatic t_eop();
        do_reset();
        qualify_pos();
        chk("R3 packet open", dv, 1'b1);
        hold(0, 0, 4);
        drive(0, 1);
        hold(0, 1, 2);
        chk("R5 four quiet cycles keep packet", dv, 1'b1);
        hold(0, 0, 6);
        chk("R6 not ended before window", dv, 1'b1);
        drive(0, 0);
        chk("R6 ended after quiet window", dv, 1'b0);
        chk("R4 select released at end", thr, 1'b0);
        hold(1, 0, 20);
        chk("R6 steady level does not requalify", dv, 1'b0);
    endtask

    task automatic t_packet();
        do_reset();
        qualify_pos();
        for (int i = 0; i < 60; i++) begin
            if (i % 15 < 3) drive(0, 0);
            else            drive((i % 4) < 2, (i % 4) >= 2);
            if (i % 10 == 9) chk("R5 valid through packet body", dv, 1'b1);
        end
    endtask

    task automatic t_reset_mid();
        do_reset();
        qualify_pos();
        rst_n = 1'b0;
        drive(1, 0);
        chk("R8 reset during packet", dv, 1'b0);
        chk("R8 reset drops select", thr, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got hung expected finish");
        summary();
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_quiet_and_lone();
        t_pnp();
        t_npn();
        t_same_pol();
        t_win_opp();
        t_win_orig();
        t_eop();
        t_packet();
        t_reset_mid();
        summary();
        $finish;
    end

endmodule